// File: doc/BRIEF.md
# Bidirectional Multiply-Add and Divide Unit

This unit runs a single shift-and-add datapath in two directions. In multiply mode it takes an N_W-bit operand A, an M_W-bit multiplier B and an N_W-bit addend R with R < A. It returns A unchanged and the (N_W+M_W)-bit result P = A·B + R. In divide mode it takes A and a P below A·2^M_W. It returns A unchanged, the quotient B = floor(P/A) and the remainder R = P mod A. Running multiply and then divide on the results gives back the original B and R exactly.

Work is sequential, one step per clock. Each step is an N_W+1-bit add or compare. A start pulse accepted while idle captures the operands. After M_W steps a one-cycle done pulse appears, and the result outputs change on that same edge. Operands that break the stated preconditions are not computed. They raise a range-error flag with all data outputs at zero.

Top module: `muldiv_bidir`

## Requirements
- R1: With dir=0 (multiply), valid operands give a_out = A, p_out = A·B + R, b_out = 0 and r_out = 0.
- R2: With dir=1 (divide), valid operands give a_out = A, b_out = floor(P/A), r_out = P mod A and p_out = 0.
- R3: A start sampled high while busy is low makes busy high on the next cycle. done pulses for one cycle, and busy falls, exactly M_W clock edges after the accepting edge.
- R4: A start raised while busy is ignored, and the running operation completes with its own operands.
- R5: a_out, p_out, b_out, r_out and range_err change only on the edge that raises done, and hold their values between completions whatever the inputs do.
- R6: In multiply mode R ≥ A (this includes A = 0) is a range error. The completion then sets range_err = 1 and forces a_out, p_out, b_out and r_out to zero.
- R7: In divide mode, A = 0 or P ≥ A·2^M_W is a range error, with the same outputs as in R6. range_err is 0 after any valid completion.
- R8: While and after synchronous reset, busy, done, range_err and all data outputs are 0.
- R9: Feeding p_out of a valid multiply back as P, with the same A, in divide mode returns the original B and R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an operation; accepted only while idle |
| dir | input | 1 | 0 = multiply-add, 1 = divide with remainder |
| a_in | input | N_W | Operand A |
| b_in | input | M_W | Multiplier B (multiply mode) |
| r_in | input | N_W | Addend R (multiply mode) |
| p_in | input | N_W+M_W | Dividend P (divide mode) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| range_err | output | 1 | Last operation violated its preconditions |
| a_out | output | N_W | A returned unchanged |
| p_out | output | N_W+M_W | Product plus addend (multiply mode) |
| b_out | output | M_W | Quotient (divide mode) |
| r_out | output | N_W | Remainder (divide mode) |

## Verification
Every result is due on the falling edge that follows the M_W-th rising edge after the edge that accepted start. Before that point the outputs must still show the previous result. The bench model loads a countdown of M_W when it accepts a start and releases its expected values when the countdown expires. Busy, done and every output are compared against it on each falling edge, so a result that comes one cycle early or late is caught, and so is a result that changes between completions. Round trips take the product from the multiply outputs and feed it back at the ports for the divide.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic {
        DIR_MUL = 1'b0,
        DIR_DIV = 1'b1
    } dir_e;

    // width of a countdown that must hold the value "steps"
    function automatic int unsigned cnt_bits(input int unsigned steps);
        return (steps < 2) ? 1 : $clog2(steps + 1);
    endfunction

endpackage

// File: rtl/mdu_guard.sv
module mdu_guard
    import muldiv_pkg::*;
#(
    parameter int unsigned N_W = 8,
    parameter int unsigned M_W = 4
) (
    input  dir_e               dir,
    input  logic [N_W-1:0]     a,
    input  logic [N_W-1:0]     r,
    input  logic [N_W+M_W-1:0] p,
    output logic               bad
);
    localparam int unsigned P_W = N_W + M_W;

    logic [P_W:0] limit;   // A * 2^M_W, one spare bit
    logic         div_bad;
    logic         mul_bad;

    always_comb begin
        limit   = {1'b0, a, {M_W{1'b0}}};
        div_bad = (a == '0) || ({1'b0, p} >= limit);
        mul_bad = (r >= a);
        bad     = (dir == DIR_DIV) ? div_bad : mul_bad;
    end

endmodule

// File: rtl/mdu_step.sv
module mdu_step
    import muldiv_pkg::*;
#(
    parameter int unsigned N_W = 8,
    parameter int unsigned M_W = 4
) (
    input  dir_e           dir,
    input  logic [N_W-1:0] a,
    input  logic [N_W-1:0] rem,
    input  logic [M_W-1:0] sh,
    output logic [N_W-1:0] rem_nx,
    output logic [M_W-1:0] sh_nx
);
    logic [N_W:0]   sum;      // multiply: rem + bit*A
    logic [N_W:0]   widened;  // divide: rem shifted left with next P bit
    logic [N_W:0]   diff;
    logic           ge;
    logic [M_W-1:0] sh_mul;
    logic [M_W-1:0] sh_div;

    always_comb begin
        sum     = {1'b0, rem} + (sh[0] ? {1'b0, a} : '0);
        widened = {rem, sh[M_W-1]};
        ge      = (widened >= {1'b0, a});
        diff    = widened - {1'b0, a};
    end

    generate
        if (M_W == 1) begin : g_single
            assign sh_mul = sum[0];
            assign sh_div = ge;
        end else begin : g_multi
            assign sh_mul = {sum[0], sh[M_W-1:1]};
            assign sh_div = {sh[M_W-2:0], ge};
        end
    endgenerate

    always_comb begin
        if (dir == DIR_DIV) begin
            rem_nx = ge ? diff[N_W-1:0] : widened[N_W-1:0];
            sh_nx  = sh_div;
        end else begin
            rem_nx = sum[N_W:1];
            sh_nx  = sh_mul;
        end
    end

endmodule

// File: rtl/mdu_seq.sv
module mdu_seq
    import muldiv_pkg::*;
#(
    parameter int unsigned M_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic load,
    output logic last,
    output logic done
);
    localparam int unsigned CW = cnt_bits(M_W);

    logic [CW-1:0] left_q;

    assign load = start && !busy;
    assign last = busy && (left_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            left_q <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                left_q <= left_q - CW'(1);
                if (left_q == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else if (start) begin
                busy   <= 1'b1;
                left_q <= CW'(M_W);
            end
        end
    end

    assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (left_q != '0 && left_q <= CW'(M_W)));

    assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

endmodule

// File: rtl/muldiv_bidir.sv
module muldiv_bidir
    import muldiv_pkg::*;
#(
    parameter int unsigned N_W = 8,
    parameter int unsigned M_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               dir,
    input  logic [N_W-1:0]     a_in,
    input  logic [M_W-1:0]     b_in,
    input  logic [N_W-1:0]     r_in,
    input  logic [N_W+M_W-1:0] p_in,
    output logic               busy,
    output logic               done,
    output logic               range_err,
    output logic [N_W-1:0]     a_out,
    output logic [N_W+M_W-1:0] p_out,
    output logic [M_W-1:0]     b_out,
    output logic [N_W-1:0]     r_out
);
    localparam int unsigned P_W = N_W + M_W;

    dir_e           dir_in;
    dir_e           dir_q;
    logic [N_W-1:0] a_q;
    logic           err_q;
    logic [N_W-1:0] rem_q;
    logic [M_W-1:0] sh_q;
    logic [N_W-1:0] rem_nx;
    logic [M_W-1:0] sh_nx;
    logic           bad;
    logic           load;
    logic           last;

    assign dir_in = dir_e'(dir);

    mdu_guard #(.N_W(N_W), .M_W(M_W)) u_guard (
        .dir (dir_in),
        .a   (a_in),
        .r   (r_in),
        .p   (p_in),
        .bad (bad)
    );

    mdu_seq #(.M_W(M_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .load  (load),
        .last  (last),
        .done  (done)
    );

    mdu_step #(.N_W(N_W), .M_W(M_W)) u_step (
        .dir    (dir_q),
        .a      (a_q),
        .rem    (rem_q),
        .sh     (sh_q),
        .rem_nx (rem_nx),
        .sh_nx  (sh_nx)
    );

    // operand capture and per-step update
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= DIR_MUL;
            a_q   <= '0;
            err_q <= 1'b0;
            rem_q <= '0;
            sh_q  <= '0;
        end else if (load) begin
            dir_q <= dir_in;
            a_q   <= a_in;
            err_q <= bad;
            if (bad) begin
                rem_q <= '0;
                sh_q  <= '0;
            end else if (dir_in == DIR_DIV) begin
                rem_q <= p_in[P_W-1:M_W];
                sh_q  <= p_in[M_W-1:0];
            end else begin
                rem_q <= r_in;
                sh_q  <= b_in;
            end
        end else if (busy) begin
            rem_q <= rem_nx;
            sh_q  <= sh_nx;
        end
    end

    // result registers, written only on the final step
    always_ff @(posedge clk) begin
        if (rst) begin
            range_err <= 1'b0;
            a_out     <= '0;
            p_out     <= '0;
            b_out     <= '0;
            r_out     <= '0;
        end else if (last) begin
            range_err <= err_q;
            if (err_q) begin
                a_out <= '0;
                p_out <= '0;
                b_out <= '0;
                r_out <= '0;
            end else if (dir_q == DIR_DIV) begin
                a_out <= a_q;
                p_out <= '0;
                b_out <= sh_nx;
                r_out <= rem_nx;
            end else begin
                a_out <= a_q;
                p_out <= {rem_nx, sh_nx};
                b_out <= '0;
                r_out <= '0;
            end
        end
    end

    assert_rem_below_a_R1: assert property (@(posedge clk) disable iff (rst)
        (busy && !err_q) |-> (rem_q < a_q));

    assert_div_rem_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (done && !range_err && dir_q == DIR_DIV) |-> (r_out < a_out));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_ignore_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (a_q == $past(a_q) && dir_q == $past(dir_q)));

    assert_hold_outputs_R5: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(p_out) && $stable(b_out) && $stable(r_out)
                   && $stable(a_out) && $stable(range_err)));

    assert_err_zero_R6: assert property (@(posedge clk) disable iff (rst)
        range_err |-> (a_out == '0 && p_out == '0 && b_out == '0 && r_out == '0));

endmodule

// File: tb/muldiv_bidir_tb.sv
module muldiv_bidir_tb;
    localparam int N = 8;
    localparam int M = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         dir = 1'b0;
    logic [N-1:0] a_in = '0;
    logic [M-1:0] b_in = '0;
    logic [N-1:0] r_in = '0;
    logic [N+M-1:0] p_in = '0;
    logic         busy, done, range_err;
    logic [N-1:0] a_out, r_out;
    logic [N+M-1:0] p_out;
    logic [M-1:0] b_out;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string cur_tag = "R8";
    bit cmp_on = 1'b0;

    // behavioural model state
    int m_busy = 0, m_done = 0, m_cnt = 0;
    int m_a = 0, m_p = 0, m_b = 0, m_r = 0, m_err = 0;
    int n_a = 0, n_p = 0, n_b = 0, n_r = 0, n_err = 0;

    always #10 clk = ~clk;

    muldiv_bidir #(.N_W(N), .M_W(M)) u_dut (
        .clk(clk), .rst(rst), .start(start), .dir(dir),
        .a_in(a_in), .b_in(b_in), .r_in(r_in), .p_in(p_in),
        .busy(busy), .done(done), .range_err(range_err),
        .a_out(a_out), .p_out(p_out), .b_out(b_out), .r_out(r_out)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_cnt = 0;
            m_a = 0; m_p = 0; m_b = 0; m_r = 0; m_err = 0;
        end else begin
            m_done = 0;
            if (m_busy != 0) begin
                if (m_cnt == 1) begin
                    m_busy = 0; m_done = 1;
                    m_a = n_a; m_p = n_p; m_b = n_b; m_r = n_r; m_err = n_err;
                end
                m_cnt = m_cnt - 1;
            end else if (start) begin
                m_busy = 1; m_cnt = M;
                if (!dir) begin
                    n_err = (int'(r_in) >= int'(a_in)) ? 1 : 0;
                    n_a = a_in; n_p = a_in * b_in + r_in; n_b = 0; n_r = 0;
                end else begin
                    n_err = (a_in == 0 || int'(p_in) >= int'(a_in) * (1 << M)) ? 1 : 0;
                    n_a = a_in; n_p = 0;
                    n_b = (a_in == 0) ? 0 : int'(p_in) / int'(a_in);
                    n_r = (a_in == 0) ? 0 : int'(p_in) % int'(a_in);
                end
                if (n_err != 0) begin
                    n_a = 0; n_p = 0; n_b = 0; n_r = 0;
                end
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            check(busy == (m_busy != 0), "R3", "busy", busy, m_busy);
            check(done == (m_done != 0), "R3", "done", done, m_done);
            check(range_err == (m_err != 0), cur_tag, "range_err", range_err, m_err);
            check(int'(a_out) == m_a, cur_tag, "a_out", a_out, m_a);
            check(int'(p_out) == m_p, cur_tag, "p_out", p_out, m_p);
            check(int'(b_out) == m_b, cur_tag, "b_out", b_out, m_b);
            check(int'(r_out) == m_r, cur_tag, "r_out", r_out, m_r);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 100000) begin
            fails++;
            $display("FAIL R3 watchdog actual=%0d expected=%0d", cycles, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic run_op(input string tag, input bit d, input int a, input int b,
                          input int r, input int p, input bit poke);
        @(negedge clk);
        cur_tag = tag;
        dir = d; a_in = N'(a); b_in = M'(b); r_in = N'(r); p_in = (N+M)'(p);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R4: a second request in mid-run must be ignored
            dir = ~d; a_in = N'(a + 3); b_in = M'(b + 1); r_in = '0; p_in = (N+M)'(p + 7);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (m_busy != 0) @(negedge clk);
    endtask

    task automatic idle_scramble(input int n);
        cur_tag = "R5";
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dir = $urandom; a_in = $urandom; b_in = $urandom; r_in = $urandom; p_in = $urandom;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(busy == 0 && done == 0, "R8", "busy|done in reset", {busy, done}, 0);
        check(range_err == 0 && a_out == 0 && p_out == 0 && b_out == 0 && r_out == 0,
              "R8", "outputs in reset", p_out, 0);
        rst = 1'b0;
        @(negedge clk);
        cmp_on = 1'b1;
        check(busy == 0 && p_out == 0, "R8", "after reset", busy, 0);

        // R1 corner and typical multiplies
        run_op("R1", 1'b0, 255, 15, 254, 0, 1'b0);
        check(p_out == 12'd4079, "R1", "max product", p_out, 4079);
        run_op("R1", 1'b0, 1, 0, 0, 0, 1'b0);
        run_op("R1", 1'b0, 37, 9, 36, 0, 1'b0);
        idle_scramble(5);
        // R2 divides
        run_op("R2", 1'b1, 1, 0, 0, 15, 1'b0);
        check(b_out == 15 && r_out == 0, "R2", "divide by one", b_out, 15);
        run_op("R2", 1'b1, 200, 0, 0, 200 * 16 - 1, 1'b0);
        check(b_out == 15 && r_out == 199, "R2", "largest P", r_out, 199);
        run_op("R2", 1'b1, 7, 0, 0, 0, 1'b0);
        // R6 multiply range errors
        run_op("R6", 1'b0, 10, 3, 10, 0, 1'b0);
        check(range_err == 1 && p_out == 0, "R6", "R equal A", range_err, 1);
        run_op("R6", 1'b0, 0, 5, 0, 0, 1'b0);
        // R7 divide range errors and recovery
        run_op("R7", 1'b1, 0, 0, 0, 5, 1'b0);
        check(range_err == 1, "R7", "A zero", range_err, 1);
        run_op("R7", 1'b1, 20, 0, 0, 320, 1'b0);
        check(range_err == 1 && b_out == 0, "R7", "P at limit", range_err, 1);
        run_op("R7", 1'b1, 20, 0, 0, 319, 1'b0);
        check(range_err == 0 && b_out == 15 && r_out == 19, "R7", "P below limit", b_out, 15);
        idle_scramble(6);
        // R4 start during busy
        run_op("R4", 1'b0, 99, 6, 50, 0, 1'b1);
        check(p_out == 99 * 6 + 50, "R4", "ignored restart", p_out, 99 * 6 + 50);
        run_op("R4", 1'b1, 13, 0, 0, 180, 1'b1);
        // R9 round trips
        for (int k = 0; k < 60; k++) begin
            int a, b, r, pv;
            a = (k == 0) ? 255 : 1 + int'($urandom % 255);
            b = (k == 0) ? 15 : int'($urandom % 16);
            r = (k == 0) ? 254 : int'($urandom % a);
            run_op("R9", 1'b0, a, b, r, 0, 1'b0);
            pv = int'(p_out);
            run_op("R9", 1'b1, a, 0, 0, pv, 1'b0);
            check(int'(b_out) == b, "R9", "round-trip B", b_out, b);
            check(int'(r_out) == r, "R9", "round-trip R", r_out, r);
            if (k % 10 == 0) idle_scramble(2);
        end
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule